// File: doc/BRIEF.md
# SPI Channel DMA Request Generator

This block produces the DMA request lines of a multichannel SPI controller. Every channel owns a pair of level requests. The receive request asks the system DMA engine to fetch a received word. The transmit request asks it to supply the next word to send. Each request follows its channel's status flag (receive data waiting, or transmit register empty). Two things gate each request: the channel enable and a per-channel DMA enable bit for that direction.

A request is not retired by a DMA acknowledge. It is retired by the register access that serves it. A strobe marking a completed read of the receive register clears the receive request. A strobe marking a completed load of the transmit register clears the transmit request. After such a strobe, the request is held low for one extra idle cycle before it may rise again. This gives the status flag time to update, so a stale flag cannot cause a second, spurious request. Software keeps the two DMA enable bits in the channel configuration word: the receive enable at bit 15 and the transmit enable at bit 14. The surrounding logic slices those bits out and drives them to this block.

Top module: `spi_dma_req_gen`

## Requirements
- R1: With the channel enabled, its receive DMA enable set and no pending hold-off, a high receive-data flag sampled at a rising clock edge makes the receive request high from that edge on.
- R2: With the channel enabled, its transmit DMA enable set and no pending hold-off, a high transmit-empty flag sampled at a rising clock edge makes the transmit request high from that edge on.
- R3: While a channel's enable is low, both of its requests are low, in the same cycle the enable falls.
- R4: While a channel's receive DMA enable is low, its receive request is low. While its transmit DMA enable is low, its transmit request is low. Both take effect in the same cycle.
- R5: A receive-read completion strobe sampled at an edge makes that channel's receive request low after that edge.
- R6: A transmit-load completion strobe sampled at an edge makes that channel's transmit request low after that edge.
- R7: After a completion strobe at edge k, the request it belongs to also stays low after edge k+1, even if every qualifying input is high. It may rise again after edge k+2.
- R8: Channels are independent: inputs of one channel never change another channel's requests.
- R9: While reset is asserted (active low), every request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | NCH | Channel enable, one bit per channel |
| rx_avail | input | NCH | Receive register holds new data |
| tx_empty | input | NCH | Transmit register is empty |
| rd_dma_en | input | NCH | Per-channel receive DMA enable (config bit 15) |
| wr_dma_en | input | NCH | Per-channel transmit DMA enable (config bit 14) |
| rd_done | input | NCH | Strobe: read of the receive register completed |
| wr_done | input | NCH | Strobe: load of the transmit register completed |
| dma_rd_req | output | NCH | Receive DMA request level |
| dma_wr_req | output | NCH | Transmit DMA request level |

## Verification
The stimulus uses flags that stay high across a completion strobe. This separates a design that honours the hold-off cycle from one that re-raises the request at once. The enable and the DMA enable bits are dropped while a request is high, to show the gating acts in the same cycle and not one edge late. Channels 0 and 1 carry opposite patterns while channels 2 and 3 sit idle or differ, which exposes any crossing of per-channel signals. Strobes are also applied to idle requests and to both directions of one channel together.

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] rx_avail,
  input  logic [NCH-1:0] tx_empty,
  input  logic [NCH-1:0] rd_dma_en,
  input  logic [NCH-1:0] wr_dma_en,
  input  logic [NCH-1:0] rd_done,
  input  logic [NCH-1:0] wr_done,
  output logic [NCH-1:0] dma_rd_req,
  output logic [NCH-1:0] dma_wr_req
);

  logic [NCH-1:0] rd_q, rd_hold, wr_q, wr_hold;
  logic [NCH-1:0] rd_ok, wr_ok;

  assign rd_ok = ch_en & rd_dma_en;
  assign wr_ok = ch_en & wr_dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      rd_hold <= '0;
      wr_q    <= '0;
      wr_hold <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (rd_done[i]) begin
          rd_q[i]    <= 1'b0;
          rd_hold[i] <= 1'b1;
        end else if (rd_hold[i]) begin
          rd_q[i]    <= 1'b0;
          rd_hold[i] <= 1'b0;
        end else begin
          rd_q[i]    <= rd_ok[i] & rx_avail[i];
        end
        if (wr_done[i]) begin
          wr_q[i]    <= 1'b0;
          wr_hold[i] <= 1'b1;
        end else if (wr_hold[i]) begin
          wr_q[i]    <= 1'b0;
          wr_hold[i] <= 1'b0;
        end else begin
          wr_q[i]    <= wr_ok[i] & tx_empty[i];
        end
      end
    end
  end

  assign dma_rd_req = rd_q & rd_ok;
  assign dma_wr_req = wr_q & wr_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_rd_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_rd_req[g]) |-> $past(rx_avail[g]) || !$past(rd_ok[g]));
    p_wr_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_wr_req[g]) |-> $past(tx_empty[g]) || !$past(wr_ok[g]));
    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |-> !dma_rd_req[g] && !dma_wr_req[g]);
    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_dma_en[g] |-> !dma_rd_req[g]) and (!wr_dma_en[g] |-> !dma_wr_req[g]));
    p_rd_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done[g] |=> !dma_rd_req[g]);
    p_wr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[g] |=> !dma_wr_req[g]);
    p_rd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done[g] |=> ##1 !dma_rd_req[g]);
    p_wr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[g] |=> ##1 !dma_wr_req[g]);
  end

endmodule

// File: tb/spi_dma_req_gen_bench.sv
module spi_dma_req_gen_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_en = '0, rx_avail = '0, tx_empty = '0;
  logic [NCH-1:0] rd_dma_en = '0, wr_dma_en = '0, rd_done = '0, wr_done = '0;
  logic [NCH-1:0] dma_rd_req, dma_wr_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [NCH-1:0] m_rq = '0, m_rh = '0, m_wq = '0, m_wh = '0;
  logic [2*NCH-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  spi_dma_req_gen #(.NCH(NCH)) u_spi_dma_req_gen (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .rx_avail(rx_avail), .tx_empty(tx_empty),
    .rd_dma_en(rd_dma_en), .wr_dma_en(wr_dma_en), .rd_done(rd_done), .wr_done(wr_done),
    .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req));

  task automatic step(input logic [NCH-1:0] en, rx, tx, rm, wm, rdd, wrd, input string tag);
    @(negedge clk);
    ch_en = en; rx_avail = rx; tx_empty = tx; rd_dma_en = rm; wr_dma_en = wm;
    rd_done = rdd; wr_done = wrd;
    #1;
    exp_q.push_back({m_wq & en & wm, m_rq & en & rm});
    tag_q.push_back(tag);
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      if (rdd[i]) begin m_rq[i] = 1'b0; m_rh[i] = 1'b1; end
      else if (m_rh[i]) begin m_rq[i] = 1'b0; m_rh[i] = 1'b0; end
      else m_rq[i] = en[i] & rm[i] & rx[i];
      if (wrd[i]) begin m_wq[i] = 1'b0; m_wh[i] = 1'b1; end
      else if (m_wh[i]) begin m_wq[i] = 1'b0; m_wh[i] = 1'b0; end
      else m_wq[i] = en[i] & wm[i] & tx[i];
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2*NCH-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if ({dma_wr_req, dma_rd_req} !== e) begin
          bad++;
          $display("FAIL %s: wr/rd req actual=%b_%b expected=%b_%b", t,
                   dma_wr_req, dma_rd_req, e[2*NCH-1:NCH], e[NCH-1:0]);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ch_en = '1; rx_avail = '1; tx_empty = '1; rd_dma_en = '1; wr_dma_en = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (dma_rd_req !== '0 || dma_wr_req !== '0) begin
      bad++;
      $display("FAIL R9: reset actual=%b_%b expected=0000_0000", dma_wr_req, dma_rd_req);
    end
    ch_en = '0; rx_avail = '0; tx_empty = '0; rd_dma_en = '0; wr_dma_en = '0;
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 R8: opposite patterns on channels 0 and 1
    step(4'b1111, 4'b0001, 4'b0010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2 R8");
    step(4'b1111, 4'b0001, 4'b0010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2 R8");
    step(4'b1111, 4'b0101, 4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2 R8");
    step(4'b1111, 4'b0101, 4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2 R8");
    // R4: masks drop while requests are high
    step(4'b1111, 4'b0101, 4'b1010, 4'b1110, 4'b1101, 4'b0000, 4'b0000, "R4");
    step(4'b1111, 4'b0101, 4'b1010, 4'b1110, 4'b1101, 4'b0000, 4'b0000, "R4");
    step(4'b1111, 4'b0101, 4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R4");
    step(4'b1111, 4'b0101, 4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R4");
    // R3: disable channels 2 and 3
    step(4'b0011, 4'b0101, 4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R3");
    step(4'b0011, 4'b0101, 4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R3");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R3");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R3");
    // R5 R7: read completion on channel 0, flag stays high
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0001, 4'b0000, "R5 R8");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R5 R7");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R7");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R7 rerise");
    // R6 R7: load completion on channel 2, also read strobe on channel 3
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1000, 4'b0100, "R6 R5");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R6 R7");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R7");
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R7 rerise");
    // both strobes on channel 1, then flags fall
    step(4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0010, 4'b0010, "R5 R6");
    step(4'b1111, 4'b1101, 4'b1101, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R7");
    step(4'b1111, 4'b1101, 4'b1101, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2");
    step(4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2");
    step(4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R1 R2");
    @(negedge clk);
    @(negedge clk);
    #3;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule